// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside the data path to a NAND flash device and watches every data word moved while that device's chip select is active. Over one page it builds a Hamming code. For each address bit, one parity bit covers the words whose index has that bit set and another covers the words whose index has it clear. Column parity bits split the data bits of each word the same way, and one overall parity bit is added. When a page is being written, the finished code is placed on `code_out` so that it can be stored in the spare area.

When a page is being read, the same code is built again and compared with the stored code that the controller places on `stored_ecc`. The difference (the syndrome) is decoded into an error report. The report shows whether there is no error, a single data-bit error (with the word index and bit index to correct), a single flipped bit in the stored code itself, or an uncorrectable multi-bit error. Page size (512, 1024, 2048 or 4096 bytes) and device width (8 or 16 bits) are chosen by control pins.

Words arrive on a valid/ready stream. `in_ready` stays high while a page is open. Once the last word of the selected page has been taken, `in_ready` drops and stays low until a `page_start` pulse opens the next page. A word transfers only on a cycle where `in_valid`, `in_ready` and `nand_cs` are all high.

Top module: `nand_ecc_engine`

## Requirements
- R1: After reset `code_out` is 0, `rpt_valid` is 0 and `in_ready` is 1.
- R2: `code_out` holds the code over the words taken so far in the page. Its bit fields are: bits [11:0] odd-index row parity, [23:12] even-index row parity, [27:24] odd-bit column parity, [31:28] even-bit column parity, and bit 32 overall parity. A data bit at bit position b of word index w toggles row bit k (odd half if bit k of w is 1, else even half), column bit j (odd half if bit j of b is 1, else even half), and the overall bit.
- R3: A page holds (512 << `page_sel`) bytes, with `page_sel` 0..3. It holds that many words when `bus16`=0 and half as many when `bus16`=1. `rpt_valid` is 0 while the last word is presented and rises in the cycle after that word is taken.
- R4: A word presented while `nand_cs` is 0 does not change the code and is not counted.
- R5: Once a page is complete, `in_ready` is 0 and further words leave `code_out` and `rpt_valid` unchanged until `page_start`.
- R6: `page_start` empties the code and restarts the word index. A word taken in the same cycle becomes word 0 of the new page.
- R7: In read mode (`rd_mode`=1), a syndrome of zero reports `err_flag`=0 and `corr_flag`=0.
- R8: In read mode, a single flipped data bit gives `err_flag`=1 and `corr_flag`=1, with `err_word` equal to the word index and `err_bit` equal to the bit index.
- R9: In read mode, a single flipped bit of the stored code gives `err_flag`, `corr_flag` and `ecc_flag` all 1, with `err_word` and `err_bit` equal to 0.
- R10: In read mode, two flipped data bits give `err_flag`=1 and `corr_flag`=0.
- R11: In write mode (`rd_mode`=0), `err_flag`, `corr_flag` and `ecc_flag` stay 0.
- R12: With `bus16`=0, the upper byte of `in_data` has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | Pulse that opens a new page |
| rd_mode | input | 1 | 1 = page read (compare), 0 = page write |
| bus16 | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| page_sel | input | 2 | Page size: 512 << page_sel bytes |
| nand_cs | input | 1 | Chip select of the NAND device; qualifies words |
| in_valid | input | 1 | Data word valid |
| in_ready | output | 1 | Engine accepts a word |
| in_data | input | 16 | Data word (low byte only in 8-bit mode) |
| stored_ecc | input | 33 | Code read back from the spare area |
| code_out | output | 33 | Code accumulated over the page |
| rpt_valid | output | 1 | Page complete; code and report final |
| err_flag | output | 1 | Syndrome non-zero |
| corr_flag | output | 1 | Error is correctable |
| ecc_flag | output | 1 | Error lies in the stored code |
| err_word | output | 12 | Index of the failing word |
| err_bit | output | 4 | Index of the failing bit |

## Verification
Opening a page and accumulating a word can happen in the same cycle. This happens when `page_start` arrives together with a qualified word, either on a completed page that is holding `in_ready` low or in the middle of a page. The bench sets up exactly that case after a finished page. It then checks that `code_out` one cycle later equals the code of that one word at index 0, that `rpt_valid` has fallen, and that the next word is taken at index 1. Chip-select-low beats are mixed into every page stream, so that a stray word cannot go unnoticed in the code comparison.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int ECC_DATA_W        = 16;
  localparam int ECC_MIN_PAGE_LOG2 = 9;
  localparam int ECC_PSEL_W        = 2;
  localparam int ECC_ADDR_W        = ECC_MIN_PAGE_LOG2 + (1 << ECC_PSEL_W) - 1;
  localparam int ECC_BIT_W         = $clog2(ECC_DATA_W);
  localparam int ECC_CODE_W        = 2 * ECC_ADDR_W + 2 * ECC_BIT_W + 1;
endpackage

// File: rtl/nand_ecc_wordcnt.sv
module nand_ecc_wordcnt #(
  parameter int ADDR_W   = 12,
  parameter int PSEL_W   = 2,
  parameter int MIN_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              beat,
  input  logic              wide,
  input  logic [PSEL_W-1:0] psel,
  output logic [ADDR_W-1:0] idx,
  output logic              done
);
  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W:0]   words;
  logic [ADDR_W-1:0] last_idx;
  logic              last;

  always_comb begin
    words = (ADDR_W+1)'(1) << (MIN_LOG2 + int'(psel));
    if (wide) words = words >> 1;
    last_idx = ADDR_W'(words - 1'b1);
    idx      = start ? '0 : cnt;
    last     = beat && (idx == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (beat)       cnt <= idx + 1'b1;
      else if (start) cnt <= '0;
      if (last)       done <= 1'b1;
      else if (start) done <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int HALF   = DATA_W / 2,
  localparam int CODE_W = 2 * ADDR_W + 2 * BIT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              wide,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] dm;
  logic              wpar;
  logic [ADDR_W-1:0] row_o, row_e;
  logic [BIT_W-1:0]  col_o, col_e;
  logic [CODE_W-1:0] delta;

  always_comb begin
    dm    = wide ? data : (data & LO_MASK);
    wpar  = ^dm;
    col_o = '0;
    col_e = '0;
    for (int k = 0; k < ADDR_W; k++) begin
      row_o[k] = idx[k] & wpar;
      row_e[k] = ~idx[k] & wpar;
    end
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < BIT_W; j++) begin
        if (((i >> j) & 1) == 1) col_o[j] = col_o[j] ^ dm[i];
        else                     col_e[j] = col_e[j] ^ dm[i];
      end
    end
    delta = {wpar, col_e, col_o, row_e, row_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code <= '0;
    else if (upd) code <= (clr ? '0 : code) ^ delta;
    else if (clr) code <= '0;
  end
endmodule

// File: rtl/nand_ecc_decode.sv
module nand_ecc_decode #(
  parameter int ADDR_W = 12,
  parameter int BIT_W  = 4,
  localparam int CODE_W = 2 * ADDR_W + 2 * BIT_W + 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] stored,
  input  logic              active,
  output logic              err,
  output logic              corr,
  output logic              ecc_only,
  output logic [ADDR_W-1:0] word,
  output logic [BIT_W-1:0]  bitpos
);
  logic [CODE_W-1:0] syn;
  logic [ADDR_W-1:0] row_o, row_e;
  logic [BIT_W-1:0]  col_o, col_e;
  logic              ovr, pairs_ok, one_bit;

  always_comb begin
    syn      = code ^ stored;
    row_o    = syn[ADDR_W-1:0];
    row_e    = syn[2*ADDR_W-1:ADDR_W];
    col_o    = syn[2*ADDR_W+BIT_W-1:2*ADDR_W];
    col_e    = syn[2*ADDR_W+2*BIT_W-1:2*ADDR_W+BIT_W];
    ovr      = syn[CODE_W-1];
    pairs_ok = (&(row_o ^ row_e)) & (&(col_o ^ col_e)) & ovr;
    one_bit  = ($countones(syn) == 1);
    err      = active & (|syn);
    corr     = active & (pairs_ok | one_bit);
    ecc_only = active & one_bit;
    word     = (active & pairs_ok) ? row_o : '0;
    bitpos   = (active & pairs_ok) ? col_o : '0;
  end
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine import nand_ecc_pkg::*; #(
  parameter int DATA_W   = ECC_DATA_W,
  parameter int MIN_LOG2 = ECC_MIN_PAGE_LOG2,
  parameter int PSEL_W   = ECC_PSEL_W,
  localparam int ADDR_W  = MIN_LOG2 + (1 << PSEL_W) - 1,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int CODE_W  = 2 * ADDR_W + 2 * BIT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_start,
  input  logic              rd_mode,
  input  logic              bus16,
  input  logic [PSEL_W-1:0] page_sel,
  input  logic              nand_cs,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CODE_W-1:0] stored_ecc,
  output logic [CODE_W-1:0] code_out,
  output logic              rpt_valid,
  output logic              err_flag,
  output logic              corr_flag,
  output logic              ecc_flag,
  output logic [ADDR_W-1:0] err_word,
  output logic [BIT_W-1:0]  err_bit
);
  logic              done;
  logic              beat;
  logic [ADDR_W-1:0] widx;

  assign in_ready  = ~done | page_start;
  assign beat      = in_valid & in_ready & nand_cs;
  assign rpt_valid = done;

  nand_ecc_wordcnt #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W), .MIN_LOG2(MIN_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(page_start), .beat(beat),
    .wide(bus16), .psel(page_sel), .idx(widx), .done(done)
  );

  nand_ecc_accum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(page_start), .upd(beat),
    .wide(bus16), .idx(widx), .data(in_data), .code(code_out)
  );

  nand_ecc_decode #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_dec (
    .code(code_out), .stored(stored_ecc), .active(done & rd_mode),
    .err(err_flag), .corr(corr_flag), .ecc_only(ecc_flag),
    .word(err_word), .bitpos(err_bit)
  );
endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk import nand_ecc_pkg::*; (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  page_start,
  input logic                  rd_mode,
  input logic                  nand_cs,
  input logic                  in_valid,
  input logic [ECC_CODE_W-1:0] code_out,
  input logic                  rpt_valid,
  input logic                  err_flag,
  input logic                  corr_flag,
  input logic                  ecc_flag,
  input logic [ECC_ADDR_W-1:0] err_word,
  input logic [ECC_BIT_W-1:0]  err_bit
);
  a_r5_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !page_start |=> $stable(code_out) && rpt_valid);

  a_r4_cs_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_cs && !page_start |=> $stable(code_out) && $stable(rpt_valid));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    page_start && !(in_valid && nand_cs) |=> (code_out == '0) && !rpt_valid);

  a_r3_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(in_valid && nand_cs));

  a_r11_write_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mode |-> !err_flag && !corr_flag && !ecc_flag);

  a_r9_code_error_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_flag |-> corr_flag && err_flag && (err_word == '0) && (err_bit == '0));

  a_r8_corr_needs_report: assert property (@(posedge clk) disable iff (!rst_n)
    corr_flag |-> err_flag && rpt_valid);
endmodule

bind nand_ecc_engine nand_ecc_engine_chk u_chk (.*);

// File: tb/nand_ecc_engine_tb_top.sv
module nand_ecc_engine_tb_top;
  import nand_ecc_pkg::*;
  localparam int AW = ECC_ADDR_W;
  localparam int BW = ECC_BIT_W;
  localparam int CW = ECC_CODE_W;

  typedef struct packed {
    logic       rd;
    logic       b16;
    logic [1:0] psel;
    logic [7:0] seed;
    logic [1:0] kind;   // 0 clean, 1 one data bit, 2 two data bits, 3 stored-code bit
    logic [11:0] fw;
    logic [3:0] fb;
    logic       e_err;
    logic       e_corr;
    logic       e_ecc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 8'd1, 2'd0, 12'd0,    4'd0,  1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'd0, 8'd2, 2'd0, 12'd0,    4'd0,  1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'd1, 8'd3, 2'd1, 12'd300,  4'd13, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 2'd2, 8'd4, 2'd1, 12'd2047, 4'd7,  1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b1, 2'd3, 8'd5, 2'd2, 12'd5,    4'd0,  1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'd0, 8'd6, 2'd3, 12'd20,   4'd0,  1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 2'd2, 8'd7, 2'd1, 12'd0,    4'd0,  1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 2'd3, 8'd8, 2'd2, 12'd4095, 4'd1,  1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 2'd1, 8'd9, 2'd1, 12'd10,   4'd2,  1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          page_start = 1'b0, rd_mode = 1'b0, bus16 = 1'b0;
  logic [1:0]    page_sel = '0;
  logic          nand_cs = 1'b0, in_valid = 1'b0, in_ready;
  logic [15:0]   in_data = '0;
  logic [CW-1:0] stored_ecc = '0, code_out;
  logic          rpt_valid, err_flag, corr_flag, ecc_flag;
  logic [AW-1:0] err_word;
  logic [BW-1:0] err_bit;

  nand_ecc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .rd_mode(rd_mode),
    .bus16(bus16), .page_sel(page_sel), .nand_cs(nand_cs), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .stored_ecc(stored_ecc),
    .code_out(code_out), .rpt_valid(rpt_valid), .err_flag(err_flag),
    .corr_flag(corr_flag), .ecc_flag(ecc_flag), .err_word(err_word), .err_bit(err_bit)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] model_upd(input logic [CW-1:0] c, input int idx,
                                              input logic [15:0] d, input bit b16);
    logic [CW-1:0] r;
    r = c;
    for (int i = 0; i < 16; i++) begin
      if ((i < 8 || b16) && d[i]) begin
        r[CW-1] = ~r[CW-1];
        for (int k = 0; k < AW; k++) begin
          if (((idx >> k) & 1) == 1) r[k] = ~r[k];
          else                       r[AW+k] = ~r[AW+k];
        end
        for (int j = 0; j < BW; j++) begin
          if (((i >> j) & 1) == 1) r[2*AW+j] = ~r[2*AW+j];
          else                     r[2*AW+BW+j] = ~r[2*AW+BW+j];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] data_of(input int idx, input int seed);
    return 16'((idx * 40503 + seed * 977) ^ (idx >> 3));
  endfunction

  task automatic run_vec(input vec_t v, input int vi);
    int words, wm;
    logic [CW-1:0] clean, drv, stored;
    logic [15:0] d;
    string ftag, ctag;
    words = (512 << v.psel) >> v.b16;
    wm    = v.b16 ? 16 : 8;
    clean = '0;
    for (int i = 0; i < words; i++) clean = model_upd(clean, i, data_of(i, v.seed), v.b16);
    stored = clean;
    if (v.kind == 2'd3) stored[v.fw] = ~stored[v.fw];
    rd_mode = v.rd; bus16 = v.b16; page_sel = v.psel; stored_ecc = stored;
    page_start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    page_start = 1'b0;
    drv = '0;
    for (int i = 0; i < words; i++) begin
      d = data_of(i, v.seed);
      if (v.kind != 2'd0 && v.kind != 2'd3 && i == int'(v.fw)) begin
        d[v.fb] = ~d[v.fb];
        if (v.kind == 2'd2) d[(int'(v.fb) + 3) % wm] = ~d[(int'(v.fb) + 3) % wm];
      end
      drv = model_upd(drv, i, d, v.b16);
      if (i % 5 == 2) begin
        nand_cs = 1'b0; in_valid = 1'b1; in_data = ~d;
        @(negedge clk);
      end
      nand_cs = 1'b1; in_valid = 1'b1; in_data = d;
      if (i == words - 1) check(rpt_valid == 1'b0, "R3", $sformatf("vec %0d early report", vi), 64'(rpt_valid), 64'd0);
      @(negedge clk);
    end
    in_valid = 1'b0; nand_cs = 1'b0;
    check(rpt_valid == 1'b1, "R3", $sformatf("vec %0d report after last word", vi), 64'(rpt_valid), 64'd1);
    ctag = (vi == 0) ? "R12" : (vi == 1) ? "R4" : "R2";
    check(code_out == drv, ctag, $sformatf("vec %0d code", vi), 64'(code_out), 64'(drv));
    check(in_ready == 1'b0, "R5", $sformatf("vec %0d ready after page", vi), 64'(in_ready), 64'd0);
    if (!v.rd)               ftag = "R11";
    else if (v.kind == 2'd0) ftag = "R7";
    else if (v.kind == 2'd1) ftag = "R8";
    else if (v.kind == 2'd2) ftag = "R10";
    else                     ftag = "R9";
    check({err_flag, corr_flag, ecc_flag} == {v.e_err, v.e_corr, v.e_ecc}, ftag,
          $sformatf("vec %0d flags", vi), 64'({err_flag, corr_flag, ecc_flag}),
          64'({v.e_err, v.e_corr, v.e_ecc}));
    if (v.rd && v.kind == 2'd1) begin
      check(err_word == v.fw, "R8", $sformatf("vec %0d word", vi), 64'(err_word), 64'(v.fw));
      check(err_bit == v.fb, "R8", $sformatf("vec %0d bit", vi), 64'(err_bit), 64'(v.fb));
    end else begin
      check(err_word == '0 && err_bit == '0, ftag, $sformatf("vec %0d no address", vi),
            64'({err_word, err_bit}), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] held, one;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(code_out == '0, "R1", "code after reset", 64'(code_out), 64'd0);
    check(rpt_valid == 1'b0, "R1", "report after reset", 64'(rpt_valid), 64'd0);
    check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);

    for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi);

    // R5: words after a completed page are refused
    held = code_out;
    for (int n = 0; n < 3; n++) begin
      nand_cs = 1'b1; in_valid = 1'b1; in_data = 16'hFFFF;
      check(in_ready == 1'b0, "R5", "ready while done", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(code_out == held, "R5", "code held", 64'(code_out), 64'(held));
    check(rpt_valid == 1'b1, "R5", "report held", 64'(rpt_valid), 64'd1);

    // R6: page_start and a word in the same cycle
    rd_mode = 1'b0; bus16 = 1'b1; page_sel = 2'd0;
    page_start = 1'b1; nand_cs = 1'b1; in_valid = 1'b1; in_data = 16'h00A5;
    @(negedge clk);
    page_start = 1'b0;
    one = model_upd('0, 0, 16'h00A5, 1'b1);
    check(code_out == one, "R6", "same-cycle word is word 0", 64'(code_out), 64'(one));
    check(rpt_valid == 1'b0, "R6", "report cleared", 64'(rpt_valid), 64'd0);
    in_data = 16'h0100;
    @(negedge clk);
    in_valid = 1'b0;
    one = model_upd(one, 1, 16'h0100, 1'b1);
    check(code_out == one, "R6", "next word is index 1", 64'(code_out), 64'(one));
    page_start = 1'b1;
    @(negedge clk);
    page_start = 1'b0;
    check(code_out == '0, "R6", "start alone clears", 64'(code_out), 64'd0);

    // R12: upper byte alone in 8-bit mode
    bus16 = 1'b0; in_valid = 1'b1; in_data = 16'hFF00;
    @(negedge clk);
    in_valid = 1'b0;
    check(code_out == '0, "R12", "upper byte ignored", 64'(code_out), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule